// File: doc/BRIEF.md
# Hidden DAC Command Register Unlock

This block watches a byte-wide I/O bus inside a VGA-compatible register window and owns a concealed 8-bit command register that sits behind the pixel-mask port. The bus carries a port offset, separate read and write strobes and write data. Software reaches the concealed register by reading the pixel-mask port a fixed number of times in a row. While the block is locked, those reads return the normal port data and advance an unlock count. Once the count is full, every read and write at the pixel-mask port goes to the command register instead. The port stays this way until a read of the DAC write-index port clears the count.

The upper three command bits choose a packed pixel format and a pixel-clock divisor. In 24-bit mode the block also scales an incoming pixel-clock value by two thirds. When no packed format is selected, 8-bit packed mode is reported only when all five standard mode conditions, driven from outside, agree. Otherwise the block reports plain VGA.

Top module: `dac_cmd_unlock`

## Requirements
- R1: After a synchronous active-high reset, `unlocked` is 0, `cmd_value` is 0x00, and `clk_div` is 1.
- R2: A read at offset 6 (pixel-mask port) while locked returns `dn_rdata` on `io_rdata` and counts as one unlock step.
- R3: The block is unlocked exactly after the fourth counted step. While unlocked, a read at offset 6 returns `cmd_value`, a write at offset 6 loads `io_wdata` into the command register, and `mask_wr_en` stays 0.
- R4: A read at offset 8 (write-index port) clears the unlock count to zero. A write at offset 8 leaves the count unchanged.
- R5: An unlocked read at offset 6 while the command register holds 0x00 returns 0x80, and the register holds 0x80 from the next cycle.
- R6: A write at offset 6 while locked raises `mask_wr_en`, does not advance the count, and leaves `cmd_value` unchanged.
- R7: Command bits [7:5] decode as follows. 101 gives `pix_fmt` 2 (15-bit) with `clk_div` 2. 111 gives `pix_fmt` 3 (16-bit) with `clk_div` 2. 011 gives `pix_fmt` 4 (24-bit) with `clk_div` 3.
- R8: Every other value of bits [7:5] gives `clk_div` 1. In that case `pix_fmt` is 1 (8-bit) only when `seq_clk_half` is 0 and `seq_chain4`, `gc_shift256`, `crtc_half` and `gfx_mode` are all 1. Otherwise `pix_fmt` is 0 (plain VGA).
- R9: `pclk_out` equals floor(`pclk_in`*2/3) when `pix_fmt` is 4, and equals `pclk_in` otherwise.
- R10: The count saturates. Once unlocked, further reads and writes at offset 6 keep the block unlocked until an offset-8 read occurs.
- R11: Accesses at offsets other than 6 and 8 change neither the count nor the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_ofs | input | 4 | Port offset within the register window |
| io_rd | input | 1 | Read strobe, one access per cycle high |
| io_wr | input | 1 | Write strobe, one access per cycle high |
| io_wdata | input | 8 | Write data |
| dn_rdata | input | 8 | Read data of the normal port at the addressed offset |
| io_rdata | output | 8 | Read data returned to the bus |
| mask_wr_en | output | 1 | Forward the current write to the normal mask register |
| cmd_value | output | 8 | Current command register contents |
| unlocked | output | 1 | Pixel-mask port is routed to the command register |
| seq_clk_half | input | 1 | Sequencer clock-halving bit |
| seq_chain4 | input | 1 | Sequencer chain-4 bit |
| gc_shift256 | input | 1 | 256-colour shift mode |
| crtc_half | input | 1 | CRTC divide-by-2 |
| gfx_mode | input | 1 | Graphics mode active |
| pclk_in | input | 32 | Selected pixel-clock value |
| pix_fmt | output | 3 | 0 VGA, 1 8-bit, 2 15-bit, 3 16-bit, 4 24-bit |
| clk_div | output | 2 | Pixel-clock divisor (1, 2 or 3) |
| pclk_out | output | 32 | Pixel-clock value after 24-bit scaling |

## Verification
The bench builds the block with its default parameters. These are a 4-bit offset, an unlock limit of four and a 32-bit clock value. Because the limit is small, random traffic crosses the lock boundary, saturates the count and clears it many times. The 32-bit clock field is wide enough that random values near the top of the range exercise the carry in the two-thirds scaling. Random command writes reach all eight decodes of the upper bits, and the random mode inputs cover both outcomes of the 8-bit condition.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    typedef enum logic [2:0] {
        FMT_VGA = 3'd0,
        FMT_8   = 3'd1,
        FMT_15  = 3'd2,
        FMT_16  = 3'd3,
        FMT_24  = 3'd4
    } pix_fmt_e;

    typedef struct packed {
        logic [7:0] cmd;
    } cmd_state_t;

    localparam logic [7:0] CMD_FORCED = 8'h80;

endpackage

// File: rtl/dac_unlock_ctr.sv
module dac_unlock_ctr #(
    parameter int ADDR_W   = 4,
    parameter int LIMIT    = 4,
    parameter int MASK_OFS = 6,
    parameter int WIDX_OFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_ofs,
    input  logic              io_rd,
    output logic              unlocked
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] WIDX_A = ADDR_W'(WIDX_OFS);
    localparam logic [CNT_W-1:0]  LIM_C  = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (io_rd && io_ofs == WIDX_A) begin
            cnt_d = '0;
        end else if (io_rd && io_ofs == MASK_A && cnt_q < LIM_C) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign unlocked = (cnt_q == LIM_C);
endmodule

// File: rtl/dac_mode_decode.sv
module dac_mode_decode
    import dac_cmd_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic [7:0]        cmd,
    input  logic              seq_clk_half,
    input  logic              seq_chain4,
    input  logic              gc_shift256,
    input  logic              crtc_half,
    input  logic              gfx_mode,
    input  logic [FREQ_W-1:0] pclk_in,
    output pix_fmt_e          fmt,
    output logic [1:0]        div,
    output logic [FREQ_W-1:0] pclk_out
);
    logic              eight_ok;
    logic [FREQ_W+1:0] dbl;
    logic [FREQ_W+1:0] scaled;

    assign eight_ok = !seq_clk_half && seq_chain4 && gc_shift256 && crtc_half && gfx_mode;

    always_comb begin
        unique case (cmd[7:5])
            3'b101:  begin fmt = FMT_15; div = 2'd2; end
            3'b111:  begin fmt = FMT_16; div = 2'd2; end
            3'b011:  begin fmt = FMT_24; div = 2'd3; end
            default: begin fmt = eight_ok ? FMT_8 : FMT_VGA; div = 2'd1; end
        endcase
    end

    assign dbl      = {2'b00, pclk_in} << 1;
    assign scaled   = dbl / 3;
    assign pclk_out = (fmt == FMT_24) ? scaled[FREQ_W-1:0] : pclk_in;
endmodule

// File: rtl/dac_cmd_unlock.sv
module dac_cmd_unlock
    import dac_cmd_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int LIMIT    = 4,
    parameter int MASK_OFS = 6,
    parameter int WIDX_OFS = 8,
    parameter int FREQ_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_ofs,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    input  logic [7:0]        dn_rdata,
    output logic [7:0]        io_rdata,
    output logic              mask_wr_en,
    output logic [7:0]        cmd_value,
    output logic              unlocked,
    input  logic              seq_clk_half,
    input  logic              seq_chain4,
    input  logic              gc_shift256,
    input  logic              crtc_half,
    input  logic              gfx_mode,
    input  logic [FREQ_W-1:0] pclk_in,
    output logic [2:0]        pix_fmt,
    output logic [1:0]        clk_div,
    output logic [FREQ_W-1:0] pclk_out
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    cmd_state_t st_d, st_q;
    logic       mask_hit;
    pix_fmt_e   fmt;

    dac_unlock_ctr #(
        .ADDR_W(ADDR_W), .LIMIT(LIMIT), .MASK_OFS(MASK_OFS), .WIDX_OFS(WIDX_OFS)
    ) u_ctr (
        .clk(clk), .rst(rst), .io_ofs(io_ofs), .io_rd(io_rd), .unlocked(unlocked)
    );

    assign mask_hit = (io_ofs == MASK_A);

    always_comb begin
        st_d       = st_q;
        io_rdata   = dn_rdata;
        mask_wr_en = 1'b0;
        if (mask_hit && unlocked) begin
            if (io_rd) begin
                if (st_q.cmd == 8'h00) begin
                    st_d.cmd = CMD_FORCED;
                    io_rdata = CMD_FORCED;
                end else begin
                    io_rdata = st_q.cmd;
                end
            end
            if (io_wr) st_d.cmd = io_wdata;
        end else if (mask_hit && io_wr) begin
            mask_wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cmd_value = st_q.cmd;

    dac_mode_decode #(.FREQ_W(FREQ_W)) u_dec (
        .cmd(st_q.cmd), .seq_clk_half(seq_clk_half), .seq_chain4(seq_chain4),
        .gc_shift256(gc_shift256), .crtc_half(crtc_half), .gfx_mode(gfx_mode),
        .pclk_in(pclk_in), .fmt(fmt), .div(clk_div), .pclk_out(pclk_out)
    );

    assign pix_fmt = fmt;
endmodule

// File: rtl/dac_cmd_unlock_chk.sv
module dac_cmd_unlock_chk #(
    parameter int ADDR_W   = 4,
    parameter int MASK_OFS = 6,
    parameter int WIDX_OFS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_ofs,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_rdata,
    input logic              mask_wr_en,
    input logic [7:0]        cmd_value,
    input logic              unlocked,
    input logic [2:0]        pix_fmt,
    input logic [1:0]        clk_div
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] WIDX_A = ADDR_W'(WIDX_OFS);

    // R4
    widx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_ofs == WIDX_A) |=> !unlocked);

    // R3
    no_fwd_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        (unlocked && io_wr && io_ofs == MASK_A) |-> !mask_wr_en);

    // R6
    locked_wr_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && io_wr && !io_rd && io_ofs == MASK_A) |=> !unlocked);

    // R10
    sticky_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (unlocked && !(io_rd && io_ofs == WIDX_A)) |=> unlocked);

    // R5
    forced_read_chk: assert property (@(posedge clk) disable iff (rst)
        (unlocked && io_rd && io_ofs == MASK_A && cmd_value == 8'h00) |-> io_rdata == 8'h80);

    // R7
    div24_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_fmt == 3'd4) |-> clk_div == 2'd3);
endmodule

bind dac_cmd_unlock dac_cmd_unlock_chk #(
    .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS), .WIDX_OFS(WIDX_OFS)
) u_chk (
    .clk(clk), .rst(rst), .io_ofs(io_ofs), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata), .mask_wr_en(mask_wr_en), .cmd_value(cmd_value),
    .unlocked(unlocked), .pix_fmt(pix_fmt), .clk_div(clk_div)
);

// File: tb/tb_dac_cmd_unlock.sv
module tb_dac_cmd_unlock;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  io_ofs;
    logic        io_rd, io_wr;
    logic [7:0]  io_wdata, dn_rdata, io_rdata, cmd_value;
    logic        mask_wr_en, unlocked;
    logic        seq_clk_half, seq_chain4, gc_shift256, crtc_half, gfx_mode;
    logic [31:0] pclk_in, pclk_out;
    logic [2:0]  pix_fmt;
    logic [1:0]  clk_div;

    int errors = 0;
    int checks = 0;
    int m_cnt;
    logic [7:0] m_cmd;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_cmd_unlock dut (
        .clk(clk), .rst(rst), .io_ofs(io_ofs), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .dn_rdata(dn_rdata), .io_rdata(io_rdata),
        .mask_wr_en(mask_wr_en), .cmd_value(cmd_value), .unlocked(unlocked),
        .seq_clk_half(seq_clk_half), .seq_chain4(seq_chain4), .gc_shift256(gc_shift256),
        .crtc_half(crtc_half), .gfx_mode(gfx_mode), .pclk_in(pclk_in),
        .pix_fmt(pix_fmt), .clk_div(clk_div), .pclk_out(pclk_out)
    );

    function automatic logic [2:0] exp_fmt(logic [7:0] c);
        case (c[7:5])
            3'b101: return 3'd2;
            3'b111: return 3'd3;
            3'b011: return 3'd4;
            default: return (!seq_clk_half && seq_chain4 && gc_shift256 && crtc_half && gfx_mode) ? 3'd1 : 3'd0;
        endcase
    endfunction

    function automatic logic [1:0] exp_div(logic [7:0] c);
        case (c[7:5])
            3'b101, 3'b111: return 2'd2;
            3'b011: return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    function automatic logic [31:0] exp_pclk(logic [7:0] c);
        logic [63:0] t;
        t = {32'd0, pclk_in} * 64'd2 / 64'd3;
        return (c[7:5] == 3'b011) ? t[31:0] : pclk_in;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state();
        chk("R3 unlocked", {31'd0, unlocked}, {31'd0, m_cnt == 4});
        chk("R11 cmd", {24'd0, cmd_value}, {24'd0, m_cmd});
        chk("R7 R8 fmt", {29'd0, pix_fmt}, {29'd0, exp_fmt(m_cmd)});
        chk("R7 R8 div", {30'd0, clk_div}, {30'd0, exp_div(m_cmd)});
        chk("R9 pclk", pclk_out, exp_pclk(m_cmd));
    endtask

    task automatic op(logic rd, logic wr, logic [3:0] ofs, logic [7:0] wd);
        logic [7:0] er;
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_ofs = ofs; io_wdata = wd;
        dn_rdata = 8'($urandom);
        #1;
        er = dn_rdata;
        if (ofs == 4'd6 && m_cnt == 4 && rd) er = (m_cmd == 8'h00) ? 8'h80 : m_cmd;
        if (rd) chk("R2 R3 R5 rdata", {24'd0, io_rdata}, {24'd0, er});
        chk("R3 R6 mask_wr_en", {31'd0, mask_wr_en}, {31'd0, wr && ofs == 4'd6 && m_cnt != 4});
        @(posedge clk);
        if (ofs == 4'd6 && m_cnt == 4) begin
            if (rd && m_cmd == 8'h00) m_cmd = 8'h80;
            if (wr) m_cmd = wd;
        end
        if (rd && ofs == 4'd8) m_cnt = 0;
        else if (rd && ofs == 4'd6 && m_cnt < 4) m_cnt++;
        @(negedge clk);
        io_rd = 0; io_wr = 0;
        #1;
        check_state();
    endtask

    task automatic unlock();
        op(1, 0, 4'd8, 8'h00);
        for (int i = 0; i < 4; i++) op(1, 0, 4'd6, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        rst = 1; io_rd = 0; io_wr = 0; io_ofs = 0; io_wdata = 0; dn_rdata = 0;
        seq_clk_half = 0; seq_chain4 = 1; gc_shift256 = 1; crtc_half = 1; gfx_mode = 1;
        pclk_in = 32'd25175000;
        m_cnt = 0; m_cmd = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        // R1 reset state
        chk("R1 unlocked", {31'd0, unlocked}, 32'd0);
        chk("R1 cmd", {24'd0, cmd_value}, 32'd0);
        chk("R1 div", {30'd0, clk_div}, 32'd1);

        // R6 locked write forwards, no step
        op(0, 1, 4'd6, 8'h60);
        // R2 three reads, still locked
        for (int i = 0; i < 3; i++) op(1, 0, 4'd6, 8'h00);
        chk("R2 still locked", {31'd0, unlocked}, 32'd0);
        // R11 other offsets don't count
        op(1, 0, 4'd9, 8'h00);
        op(0, 1, 4'd7, 8'hff);
        op(1, 0, 4'd6, 8'h00);
        chk("R3 unlocked after fourth", {31'd0, unlocked}, 32'd1);
        // R5 zero read forced
        op(1, 0, 4'd6, 8'h00);
        chk("R5 stored", {24'd0, cmd_value}, 32'h80);
        // R7 decodes
        op(0, 1, 4'd6, 8'hA0); chk("R7 15bit", {29'd0, pix_fmt}, 32'd2);
        op(0, 1, 4'd6, 8'hE0); chk("R7 16bit", {29'd0, pix_fmt}, 32'd3);
        pclk_in = 32'hFFFF_FFFF;
        op(0, 1, 4'd6, 8'h60); chk("R7 24bit div", {30'd0, clk_div}, 32'd3);
        chk("R9 max clock", pclk_out, 32'hAAAA_AAAA);
        // R4 write to index does not clear, R10 saturation
        op(0, 1, 4'd8, 8'h00);
        op(1, 0, 4'd6, 8'h00);
        chk("R10 R4 still unlocked", {31'd0, unlocked}, 32'd1);
        op(1, 0, 4'd8, 8'h00);
        chk("R4 cleared", {31'd0, unlocked}, 32'd0);
        // R8 8-bit condition broken
        seq_clk_half = 1;
        unlock();
        op(0, 1, 4'd6, 8'h00);
        chk("R8 vga", {29'd0, pix_fmt}, 32'd0);

        for (int n = 0; n < 3000; n++) begin
            logic [3:0] o;
            logic r;
            int k;
            k = int'($urandom_range(0, 9));
            o = (k < 5) ? 4'd6 : (k < 7) ? 4'd8 : 4'($urandom);
            r = $urandom_range(0, 1) == 1;
            {seq_clk_half, seq_chain4, gc_shift256, crtc_half, gfx_mode} = 5'($urandom);
            if ($urandom_range(0, 2) != 0) {seq_clk_half, seq_chain4, gc_shift256, crtc_half, gfx_mode} = 5'b01111;
            pclk_in = $urandom;
            op(r, !r, o, 8'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule